// File: doc/BRIEF.md
# Three-Level Nesting Interrupt Arbiter

This block sits between a set of peripheral request lines and a processor core. Each source has its own enable bit and a two-bit level code that selects low, medium or high priority. A separate non-maskable request line outranks every level. In each cycle the block picks the request the core should take next. It then emits a one-cycle take strobe and the vector word address of the handler.

The block keeps one active bit per level so that handlers can nest. A request is taken only when its level is strictly above the highest level already in service. A return pulse from the core ends the innermost handler by clearing the highest active bit. Within a level the lowest source index wins, because it has the lowest vector address. The low level can be switched to a rotating order, so that no low source waits forever. A configuration bit moves the whole vector table from address zero to a boot-area base.

Top module: `mlvl_irq_ctrl`

## Requirements
- R1: After reset, `take` is 0, `vector` is 0 and `active` is 0.
- R2: Among enabled, pending sources of one level, the lowest index is taken. Source i gets vector base + 4 + 2*i.
- R3: Level codes are 00 low, 01 medium, 1x high. A request is taken only if its level is above the highest set bit of `active` = {nmi, high, medium, low}. A taken request sets its bit one cycle after the inputs are presented, together with `take`.
- R4: `nmi_req` outranks all levels and ignores every enable. It is taken while a high handler is active, gets vector base + 2 and sets `active[3]`.
- R5: A one-cycle `reti` clears only the highest set bit of `active`.
- R6: A source whose `src_en` bit is 0 is never taken. It is taken once enabled if its request is still held.
- R7: While `lvl_en[l]` is 0 (bit 0 low, 1 medium, 2 high), level l produces no take. A held request is taken as soon as the bit returns to 1.
- R8: With `boot_sel` at 1 the base is BOOT_BASE instead of 0.
- R9: With `rr_en` at 1, the block remembers the index of each low source it takes. The next low search then starts at that index plus one and wraps. After reset the search starts at index 0.
- R10: With `rr_en` at 0, low arbitration is fixed-priority and is not changed by takes or returns.
- R11: A `reti` and a new take in the same cycle both apply: the highest old bit is cleared and the new level's bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | N_SRC | Level-held request per source |
| nmi_req | input | 1 | Non-maskable request |
| src_en | input | N_SRC | Per-source enable |
| src_lvl | input | 2*N_SRC | Level code per source, bits [2i+1:2i] |
| lvl_en | input | 3 | Global enable per level (low, medium, high) |
| rr_en | input | 1 | Rotating order at the low level |
| boot_sel | input | 1 | Vector table at BOOT_BASE |
| reti | input | 1 | Return-from-handler pulse |
| take | output | 1 | One-cycle strobe: the core takes `vector` |
| vector | output | VEC_W | Handler word address |
| active | output | 4 | In-service bits {nmi, high, medium, low} |

## Verification
A return and a new take can land on the same clock edge. The return clears one bit of the nesting state while the take sets another. The bench provokes this by raising a medium request in the very cycle it pulses `reti` with only the low handler in service. It then expects one take with the medium vector and an `active` value of medium alone. A scoreboard of expected vectors and status values flags any extra take, any missing take or any take out of order. That covers the blocked-level cases as well as the rotating low order.

// File: rtl/irq_pkg.sv
// Shared definitions for the nesting interrupt arbiter.
// Assumes level codes of two bits: 00 low, 01 medium, 1x high.
package irq_pkg;

    localparam int NUM_LVL = 3;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MED  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_t;

    // Map a source's two-bit code to its level index.
    function automatic lvl_t lvl_decode(input logic [1:0] code);
        if (code[1])      return LVL_HIGH;
        else if (code[0]) return LVL_MED;
        else              return LVL_LOW;
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
// Fixed-priority finder: reports whether any bit is set and the lowest set index.
// Assumes N >= 2; purely combinational.
module irq_prio_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend,
    output logic          hit,
    output logic [IW-1:0] idx
);

    // Scan from the top down so the lowest set index is the one that remains.
    always_comb begin
        hit = |pend;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/irq_rr_pick.sv
// Rotating finder: searches upward from last+1 with wrap-around, so the
// most recently served index has the lowest priority.
// Assumes the caller only uses idx when some bit of pend is set.
module irq_rr_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] idx
);

    // Walk the ring once starting after 'last'; keep the first hit.
    always_comb begin
        logic found;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(last) + 1 + k) % N;
            if (!found && pend[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end

endmodule

// File: rtl/irq_nest_track.sv
// In-service tracker: one bit per level {nmi, high, medium, low}.
// A return clears only the highest set bit; a take sets its own bit.
// Assumes the bit being set is above every bit currently set, so the
// set and clear of one edge never touch the same bit.
module irq_nest_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] set_bits,
    input  logic       reti,
    output logic [3:0] active
);

    logic [3:0] clr_bits;

    // Locate the innermost (highest) active level for a return.
    always_comb begin
        clr_bits = '0;
        for (int i = 0; i < 4; i++) begin
            if (active[i]) begin
                clr_bits    = '0;
                clr_bits[i] = 1'b1;
            end
        end
    end

    // Apply the return clear and the new take in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= '0;
        else        active <= (active & ~(reti ? clr_bits : 4'b0000)) | set_bits;
    end

endmodule

// File: rtl/mlvl_irq_ctrl.sv
// Three-level nesting interrupt arbiter with a non-maskable input.
// Filters requests by source enable, level code and level enable. Picks
// the lowest index per level (or a rotating order at the low level),
// admits only levels above the innermost active one, and registers a
// take strobe with the handler vector.
// Assumes requests are held until served and reti is a one-cycle pulse.
module mlvl_irq_ctrl
    import irq_pkg::*;
#(
    parameter int          N_SRC     = 8,
    parameter int          VEC_W     = 16,
    parameter int unsigned BOOT_BASE = 32'h0200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   irq_req,
    input  logic               nmi_req,
    input  logic [N_SRC-1:0]   src_en,
    input  logic [2*N_SRC-1:0] src_lvl,
    input  logic [2:0]         lvl_en,
    input  logic               rr_en,
    input  logic               boot_sel,
    input  logic               reti,
    output logic               take,
    output logic [VEC_W-1:0]   vector,
    output logic [3:0]         active
);

    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [VEC_W-1:0] NMI_OFS  = VEC_W'(2);
    localparam logic [VEC_W-1:0] SRC_OFS0 = VEC_W'(4);

    logic [N_SRC-1:0] lvl_pend [NUM_LVL];
    logic [NUM_LVL-1:0] lvl_hit;
    logic [IW-1:0]    lvl_idx [NUM_LVL];
    logic [IW-1:0]    rr_idx;
    logic [IW-1:0]    rr_last;
    logic [IW-1:0]    lo_idx;
    logic             nmi_ok, hi_ok, med_ok, lo_ok;
    logic [3:0]       win_set;
    logic [IW-1:0]    win_idx;
    logic [VEC_W-1:0] base, vec_d;

    // Per-level request masks and one fixed-priority finder per level.
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            assign lvl_pend[l][i] = irq_req[i] & src_en[i] & lvl_en[l]
                                  & (lvl_decode(src_lvl[2*i +: 2]) == lvl_t'(l));
        end
        irq_prio_pick #(.N(N_SRC)) u_pick (
            .pend (lvl_pend[l]),
            .hit  (lvl_hit[l]),
            .idx  (lvl_idx[l])
        );
    end

    // Rotating finder used only for the low level.
    irq_rr_pick #(.N(N_SRC)) u_rr (
        .pend (lvl_pend[LVL_LOW]),
        .last (rr_last),
        .idx  (rr_idx)
    );

    assign lo_idx = rr_en ? rr_idx : lvl_idx[LVL_LOW];

    // Admission: a level may enter only above the innermost active level.
    always_comb begin
        nmi_ok = nmi_req & ~active[3];
        hi_ok  = lvl_hit[LVL_HIGH] & ~(|active[3:2]);
        med_ok = lvl_hit[LVL_MED]  & ~(|active[3:1]);
        lo_ok  = lvl_hit[LVL_LOW]  & ~(|active);
    end

    // Choose the winning level and source, non-maskable first.
    always_comb begin
        win_set = '0;
        win_idx = '0;
        if (nmi_ok) begin
            win_set[3] = 1'b1;
        end else if (hi_ok) begin
            win_set[2] = 1'b1;
            win_idx    = lvl_idx[LVL_HIGH];
        end else if (med_ok) begin
            win_set[1] = 1'b1;
            win_idx    = lvl_idx[LVL_MED];
        end else if (lo_ok) begin
            win_set[0] = 1'b1;
            win_idx    = lo_idx;
        end
    end

    // Vector address: table base plus the winner's offset.
    always_comb begin
        base  = boot_sel ? VEC_W'(BOOT_BASE) : '0;
        vec_d = win_set[3] ? base + NMI_OFS
                           : base + SRC_OFS0 + VEC_W'({win_idx, 1'b0});
    end

    // Register the take strobe and the vector together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take   <= 1'b0;
            vector <= '0;
        end else begin
            take <= |win_set;
            if (|win_set) vector <= vec_d;
        end
    end

    // Remember the last low source served, in rotating mode only.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rr_last <= IW'(N_SRC - 1);
        else if (win_set[0] && rr_en)  rr_last <= lo_idx;
    end

    irq_nest_track u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (win_set),
        .reti     (reti),
        .active   (active)
    );

endmodule

// File: rtl/irq_ctrl_chk.sv
// Property checker for the nesting interrupt arbiter, bound to its top.
// Assumes the same parameter values as the bound instance.
module irq_ctrl_chk #(
    parameter int          VEC_W     = 16,
    parameter int unsigned BOOT_BASE = 32'h0200
) (
    input logic             clk,
    input logic             rst_n,
    input logic             boot_sel,
    input logic             reti,
    input logic             take,
    input logic [VEC_W-1:0] vector,
    input logic [3:0]       active
);

    // R3: a take without a concurrent return adds exactly one level.
    a_r3_take_nests: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !$past(reti)) |-> ($countones(active) == $countones($past(active)) + 1));

    // R2: vectors are word addresses on even positions.
    a_r2_vec_even: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (vector[0] == 1'b0));

    // R4: entering the non-maskable level yields base + 2.
    a_r4_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (take && active[3] && !$past(active[3]))
        |-> (vector == (($past(boot_sel) ? VEC_W'(BOOT_BASE) : VEC_W'(0)) + VEC_W'(2))));

    // R4: once in service, the non-maskable bit stays until a return.
    a_r4_nmi_held: assert property (@(posedge clk) disable iff (!rst_n)
        (active[3] && !reti) |=> active[3]);

    // R5: a return never increases the number of active levels.
    a_r5_reti_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && active != 4'b0000) |=> ($countones(active) <= $countones($past(active))));

endmodule

bind mlvl_irq_ctrl irq_ctrl_chk #(
    .VEC_W     (VEC_W),
    .BOOT_BASE (BOOT_BASE)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot_sel (boot_sel),
    .reti     (reti),
    .take     (take),
    .vector   (vector),
    .active   (active)
);

// File: tb/test_mlvl_irq_ctrl.sv
module test_mlvl_irq_ctrl;

    localparam int N     = 8;
    localparam int VW    = 16;
    localparam int BOOTB = 32'h0200;

    typedef struct {
        logic [VW-1:0] vec;
        logic [3:0]    act;
        string         tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq_req = '0;
    logic            nmi_req = 1'b0;
    logic [N-1:0]    src_en = '1;
    logic [2*N-1:0]  src_lvl = '0;
    logic [2:0]      lvl_en = 3'b111;
    logic            rr_en = 1'b0;
    logic            boot_sel = 1'b0;
    logic            reti = 1'b0;
    logic            take;
    logic [VW-1:0]   vector;
    logic [3:0]      active;

    int checks = 0;
    int fails  = 0;
    item_t q[$];

    always #5 clk = ~clk;

    mlvl_irq_ctrl #(.N_SRC(N), .VEC_W(VW), .BOOT_BASE(BOOTB)) i_mlvl_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
        .src_en(src_en), .src_lvl(src_lvl), .lvl_en(lvl_en), .rr_en(rr_en),
        .boot_sel(boot_sel), .reti(reti), .take(take), .vector(vector),
        .active(active)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_take(input logic [VW-1:0] v, input logic [3:0] a, input string tag);
        item_t it;
        it.vec = v; it.act = a; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic pulse_reti;
        reti = 1'b1;
        tick(1);
        reti = 1'b0;
    endtask

    task automatic check(input logic ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act_v, exp_v);
        end
    endtask

    function automatic logic [VW-1:0] sv(input int i);
        return VW'(4 + 2 * i);
    endfunction

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Monitor: pop and compare on every take, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && take) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R3/R6/R7 unexpected take: got vector %h active %b, expected none", vector, active);
            end else begin
                item_t it;
                it = q.pop_front();
                if (vector !== it.vec || active !== it.act) begin
                    fails++;
                    $display("FAIL %s: got vector %h active %b, expected %h %b",
                             it.tag, vector, active, it.vec, it.act);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        src_lvl[13:12] = 2'b01;   // source 6 medium
        src_lvl[15:14] = 2'b10;   // source 7 high
        src_lvl[9:8]   = 2'b01;   // source 4 medium
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(take === 1'b0 && active === 4'b0 && vector === '0, "R1 reset", {take, active, vector}, 0);

        // R2: lowest index among low sources 3 and 5
        expect_take(sv(3), 4'b0001, "R2 lowest index");
        irq_req[3] = 1'b1; irq_req[5] = 1'b1;
        tick(3);
        irq_req[3] = 1'b0;
        expect_take(sv(5), 4'b0001, "R2 next after return");
        pulse_reti();
        tick(3);
        check(active === 4'b0001, "R2 second low active", active, 4'b0001);
        irq_req[5] = 1'b0;
        pulse_reti();
        tick(2);
        check(active === 4'b0000, "R5 idle after return", active, 0);

        // R3 nesting low -> medium -> (low blocked) -> high -> R4 nmi
        expect_take(sv(1), 4'b0001, "R3 low enters");
        irq_req[1] = 1'b1; tick(3); irq_req[1] = 1'b0;
        expect_take(sv(6), 4'b0011, "R3 medium preempts low");
        irq_req[6] = 1'b1; tick(3); irq_req[6] = 1'b0;
        irq_req[2] = 1'b1; tick(4);
        check(active === 4'b0011, "R3 low blocked under medium", active, 4'b0011);
        expect_take(sv(7), 4'b0111, "R3 high preempts medium");
        irq_req[7] = 1'b1; tick(3); irq_req[7] = 1'b0;
        expect_take(VW'(2), 4'b1111, "R4 nmi over high");
        nmi_req = 1'b1; tick(3); nmi_req = 1'b0;
        pulse_reti();
        check(active === 4'b0111, "R5 clears nmi only", active, 4'b0111);
        pulse_reti();
        check(active === 4'b0011, "R5 clears high only", active, 4'b0011);
        pulse_reti();
        check(active === 4'b0001, "R5 clears medium only", active, 4'b0001);
        expect_take(sv(2), 4'b0001, "R3 held low taken after return");
        pulse_reti();
        tick(3);
        irq_req[2] = 1'b0;
        pulse_reti();
        tick(2);

        // R11: return and medium take in one cycle
        expect_take(sv(0), 4'b0001, "R11 setup low");
        irq_req[0] = 1'b1; tick(3); irq_req[0] = 1'b0;
        expect_take(sv(4), 4'b0010, "R11 take with return");
        reti = 1'b1; irq_req[4] = 1'b1;
        tick(1);
        reti = 1'b0;
        tick(2);
        check(active === 4'b0010, "R11 status after joint edge", active, 4'b0010);
        irq_req[4] = 1'b0;
        pulse_reti();
        tick(2);

        // R6: disabled source
        src_en[3] = 1'b0; irq_req[3] = 1'b1;
        tick(5);
        check(active === 4'b0000, "R6 disabled source ignored", active, 0);
        expect_take(sv(3), 4'b0001, "R6 taken once enabled");
        src_en[3] = 1'b1;
        tick(3);
        irq_req[3] = 1'b0;
        pulse_reti();
        tick(2);

        // R7: disabled level keeps its request
        lvl_en[1] = 1'b0; irq_req[4] = 1'b1;
        tick(5);
        check(active === 4'b0000, "R7 medium level disabled", active, 0);
        expect_take(sv(4), 4'b0010, "R7 taken after level enable");
        lvl_en[1] = 1'b1;
        tick(3);
        irq_req[4] = 1'b0;
        pulse_reti();
        tick(2);

        // R4: nmi ignores every enable
        lvl_en = 3'b000; src_en = '0;
        expect_take(VW'(2), 4'b1000, "R4 nmi ignores enables");
        nmi_req = 1'b1; tick(3); nmi_req = 1'b0;
        pulse_reti();
        tick(2);
        check(active === 4'b0000, "R5 nmi return", active, 0);
        lvl_en = 3'b111; src_en = '1;

        // R8: boot base
        boot_sel = 1'b1;
        expect_take(VW'(BOOTB) + sv(0), 4'b0001, "R8 boot base");
        irq_req[0] = 1'b1; tick(3); irq_req[0] = 1'b0;
        pulse_reti();
        tick(2);
        boot_sel = 1'b0;

        // R9: rotating low order with 1,3,5 held
        rr_en = 1'b1;
        expect_take(sv(1), 4'b0001, "R9 rotation first");
        expect_take(sv(3), 4'b0001, "R9 rotation second");
        expect_take(sv(5), 4'b0001, "R9 rotation third");
        expect_take(sv(1), 4'b0001, "R9 rotation wraps");
        irq_req[1] = 1'b1; irq_req[3] = 1'b1; irq_req[5] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick(3);
            if (k == 3) irq_req = '0;
            pulse_reti();
        end
        tick(2);

        // R10: fixed order is unaffected by returns
        rr_en = 1'b0;
        expect_take(sv(1), 4'b0001, "R10 fixed first");
        expect_take(sv(1), 4'b0001, "R10 fixed repeat");
        irq_req[1] = 1'b1; irq_req[3] = 1'b1; irq_req[5] = 1'b1;
        for (int k = 0; k < 2; k++) begin
            tick(3);
            if (k == 1) irq_req = '0;
            pulse_reti();
        end
        tick(3);

        check(q.size() == 0, "R2 scoreboard drained", q.size(), 0);
        summary();
    end

endmodule